// File: doc/BRIEF.md
# Stack Frame Release Sequencer

This block performs the frame-exit step of a simple processor core. On a start strobe it takes the current frame pointer as the new stack pointer. It then reads the saved frame pointer from memory at that address and writes it back into the frame-pointer register. The stack pointer ends up advanced past the popped value. The width of the pointer copy comes from the stack size, and the width of the pop comes from the operand size; the two are chosen independently. Execution mode can force either width.

Every fault check that depends only on the captured inputs runs one cycle after start, before any memory traffic. These are the lock check, the segment, real-range and canonical checks, and the alignment check. A fault reported with the read response is the one late fault. Any fault leaves both pointer registers untouched. The block issues one single-beat read and then ends in one of two ways: a single write-back cycle that strobes both pointers together, or a single fault cycle that carries a fault class.

Top module: `frame_exit_seq`

## Requirements
- R1: A start strobe while idle is accepted and busy_o is high from the next cycle up to and including the write-back or fault cycle, then low. A start strobe while busy_o is high is ignored, and inputs that change after acceptance do not alter the result.
- R2: The stack width is 64 bits in 64-bit mode (mode_i=3) whatever stk_size_i says. In other modes stk_size_i=0 selects 16 bits and any other code selects 32 bits. The copy replaces only that many low bits of the stack pointer and keeps the bits above them.
- R3: The read address is the frame pointer cut to the stack width and zero-extended. After the data returns, the written stack pointer is that address plus the pop size in bytes (2, 4 or 8), wrapping inside the stack width. sp_we_o and fp_we_o pulse together for one cycle.
- R4: op_size_i=0 selects a 16-bit pop. Any other code selects 32 bits, except in 64-bit mode, where it selects 64 bits. rd_size_o reports the pop width as 0=16, 1=32, 2=64. The popped data replaces that many low bits of the frame pointer and keeps the bits above them.
- R5: lock_i raises fault class 1 (invalid opcode) in every mode and issues no read.
- R6: In real mode (0) and virtual-8086 mode (1), a pop whose last byte lies above FFFFh raises fault class 2 (general protection).
- R7: In protected or compatibility mode (2), a pop whose first byte is below seg_lo_i or whose last byte is above seg_hi_i raises fault class 3 (stack fault).
- R8: In 64-bit mode, a read address whose bits 63 to 47 are not all equal raises fault class 3.
- R9: When ac_en_i is set and the read address is not a multiple of the pop size, fault class 4 (alignment) is raised. This applies in mode 1 at any privilege, and in modes 2 and 3 only when cpl_i=3. It never applies in mode 0.
- R10: A read response with rd_pf_i set raises fault class 5 (page fault).
- R11: A fault is one cycle of fault_o with a nonzero class and no pointer strobe. Faults of classes 1 to 4 are raised before any read is requested.
- R12: Priority is class 1 first, then the range, segment or canonical fault (class 2 or 3), then class 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame release |
| mode_i | input | 2 | 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| stk_size_i | input | 2 | Stack size code |
| op_size_i | input | 2 | Operand size code |
| cpl_i | input | 2 | Current privilege level |
| ac_en_i | input | 1 | Alignment checking enabled |
| lock_i | input | 1 | Lock prefix present |
| fp_i | input | 64 | Current frame pointer |
| sp_i | input | 64 | Current stack pointer |
| seg_lo_i | input | 64 | Lowest valid stack segment address |
| seg_hi_i | input | 64 | Highest valid stack segment address |
| rd_req_o | output | 1 | Read request, held until response |
| rd_addr_o | output | 64 | Read address |
| rd_size_o | output | 2 | Read width code |
| rd_vld_i | input | 1 | Read response valid |
| rd_data_i | input | 64 | Read data |
| rd_pf_i | input | 1 | Page fault on the read |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | 64 | New stack pointer |
| fp_we_o | output | 1 | Frame pointer write strobe |
| fp_wdata_o | output | 64 | New frame pointer |
| fault_o | output | 1 | Fault strobe |
| fault_cls_o | output | 3 | Fault class |
| busy_o | output | 1 | Operation in progress |

## Verification
The case of interest is a new start strobe that lands in the same cycle as the write-back of the operation in flight, or in a cycle while its read is still pending. The bench raises start_i with different pointer values in exactly the cycle where sp_we_o is seen high, and in a separate run halfway through a delayed read response. It then requires three things: the written pointers match the first operation, busy_o drops after the write-back cycle and stays low, and no second read request appears. Two fault conditions falling on the same operation, such as a misaligned pop past the segment limit, are judged by the class that appears.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    MD_REAL = 2'd0,
    MD_V86  = 2'd1,
    MD_PROT = 2'd2,
    MD_LONG = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_32 = 2'd1,
    SZ_64 = 2'd2
  } size_e;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_GP   = 3'd2,
    FLT_SS   = 3'd3,
    FLT_AC   = 3'd4,
    FLT_PF   = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_RD, ST_WB, ST_FLT
  } state_e;

  function automatic int size_bits(size_e s);
    case (s)
      SZ_16:   return 16;
      SZ_32:   return 32;
      default: return 64;
    endcase
  endfunction

  function automatic logic [3:0] size_bytes(size_e s);
    case (s)
      SZ_16:   return 4'd2;
      SZ_32:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/frx_merge.sv
module frx_merge
  import frx_pkg::*;
#(
  parameter int XLEN = frx_pkg::XLEN
) (
  input  size_e            size_i,
  input  logic [XLEN-1:0]  old_i,
  input  logic [XLEN-1:0]  new_i,
  output logic [XLEN-1:0]  out_o
);
  logic [XLEN-1:0] mask;
  int              w;

  always_comb begin
    w    = size_bits(size_i);
    mask = (w >= XLEN) ? '1 : ((XLEN'(1) << w) - XLEN'(1));
    out_o = (old_i & ~mask) | (new_i & mask);
  end
endmodule

// File: rtl/frx_addr_gen.sv
module frx_addr_gen
  import frx_pkg::*;
#(
  parameter int XLEN = frx_pkg::XLEN
) (
  input  mode_e            mode_i,
  input  logic [1:0]       stk_code_i,
  input  logic [1:0]       op_code_i,
  input  logic [XLEN-1:0]  fp_i,
  input  logic [XLEN-1:0]  sp_i,
  output size_e            stk_sz_o,
  output size_e            pop_sz_o,
  output logic [XLEN-1:0]  pop_addr_o,
  output logic [XLEN-1:0]  pop_last_o,
  output logic [XLEN-1:0]  sp_next_o
);
  logic            long_md;
  logic [XLEN-1:0] stk_mask;
  logic [XLEN-1:0] pop_bytes;
  logic [XLEN-1:0] sp_raw;
  int              stk_w;

  always_comb begin
    long_md   = (mode_i == MD_LONG);
    // 64-bit mode forces a 64-bit stack; a 32-bit pop request there widens to 64
    stk_sz_o  = long_md ? SZ_64 : ((stk_code_i == 2'd0) ? SZ_16 : SZ_32);
    pop_sz_o  = (op_code_i == 2'd0) ? SZ_16 : (long_md ? SZ_64 : SZ_32);
    stk_w     = size_bits(stk_sz_o);
    stk_mask  = (stk_w >= XLEN) ? '1 : ((XLEN'(1) << stk_w) - XLEN'(1));
    pop_bytes = XLEN'(size_bytes(pop_sz_o));
    pop_addr_o = fp_i & stk_mask;
    // unwrapped last byte, used by range and limit checks
    pop_last_o = pop_addr_o + pop_bytes - XLEN'(1);
    sp_raw     = pop_addr_o + pop_bytes;
  end

  frx_merge #(.XLEN(XLEN)) u_sp_merge (
    .size_i (stk_sz_o),
    .old_i  (sp_i),
    .new_i  (sp_raw),
    .out_o  (sp_next_o)
  );
endmodule

// File: rtl/frx_fault_chk.sv
module frx_fault_chk
  import frx_pkg::*;
#(
  parameter int              XLEN     = frx_pkg::XLEN,
  parameter int              VA_BITS  = 48,
  parameter logic [XLEN-1:0] RM_LIMIT = XLEN'(16'hFFFF)
) (
  input  mode_e            mode_i,
  input  logic [1:0]       cpl_i,
  input  logic             ac_en_i,
  input  logic             lock_i,
  input  size_e            pop_sz_i,
  input  logic [XLEN-1:0]  pop_addr_i,
  input  logic [XLEN-1:0]  pop_last_i,
  input  logic [XLEN-1:0]  seg_lo_i,
  input  logic [XLEN-1:0]  seg_hi_i,
  output fault_e           cls_o
);
  localparam int CANON_LSB = VA_BITS - 1;

  logic [XLEN-1:CANON_LSB] top_bits;
  logic                    seg_bad;
  fault_e                  seg_cls;
  logic                    ac_scope;
  logic                    misalign;
  logic [2:0]              low_mask;

  always_comb begin
    top_bits = pop_addr_i[XLEN-1:CANON_LSB];
    seg_bad  = 1'b0;
    seg_cls  = FLT_SS;
    case (mode_i)
      MD_REAL, MD_V86: begin
        seg_bad = (pop_last_i > RM_LIMIT);
        seg_cls = FLT_GP;
      end
      MD_PROT: seg_bad = (pop_addr_i < seg_lo_i) || (pop_last_i > seg_hi_i);
      default: seg_bad = !((&top_bits) || !(|top_bits));
    endcase

    low_mask = size_bytes(pop_sz_i)[2:0] - 3'd1;
    misalign = |(pop_addr_i[2:0] & low_mask);
    ac_scope = (mode_i == MD_V86) ||
               (((mode_i == MD_PROT) || (mode_i == MD_LONG)) && (cpl_i == 2'd3));

    if (lock_i)                           cls_o = FLT_UD;
    else if (seg_bad)                     cls_o = seg_cls;
    else if (ac_en_i && ac_scope && misalign) cls_o = FLT_AC;
    else                                  cls_o = FLT_NONE;
  end
endmodule

// File: rtl/frx_ctrl.sv
module frx_ctrl
  import frx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  fault_e chk_cls_i,
  input  logic   rd_vld_i,
  input  logic   rd_pf_i,
  output logic   capture_o,
  output logic   take_data_o,
  output logic   busy_o,
  output logic   rd_req_o,
  output logic   wb_o,
  output logic   fault_o,
  output fault_e fault_cls_o
);
  state_e state_q;
  fault_e cls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cls_q   <= FLT_NONE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_CHK;
        ST_CHK: begin
          if (chk_cls_i != FLT_NONE) begin
            cls_q   <= chk_cls_i;
            state_q <= ST_FLT;
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (rd_vld_i) begin
            if (rd_pf_i) begin
              cls_q   <= FLT_PF;
              state_q <= ST_FLT;
            end else begin
              state_q <= ST_WB;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    capture_o   = (state_q == ST_IDLE) && start_i;
    take_data_o = (state_q == ST_RD) && rd_vld_i && !rd_pf_i;
    busy_o      = (state_q != ST_IDLE);
    rd_req_o    = (state_q == ST_RD);
    wb_o        = (state_q == ST_WB);
    fault_o     = (state_q == ST_FLT);
    fault_cls_o = fault_o ? cls_q : FLT_NONE;
  end
endmodule

// File: rtl/frame_exit_seq.sv
module frame_exit_seq
  import frx_pkg::*;
#(
  parameter int XLEN    = frx_pkg::XLEN,
  parameter int VA_BITS = 48
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      mode_i,
  input  logic [1:0]      stk_size_i,
  input  logic [1:0]      op_size_i,
  input  logic [1:0]      cpl_i,
  input  logic            ac_en_i,
  input  logic            lock_i,
  input  logic [XLEN-1:0] fp_i,
  input  logic [XLEN-1:0] sp_i,
  input  logic [XLEN-1:0] seg_lo_i,
  input  logic [XLEN-1:0] seg_hi_i,
  output logic            rd_req_o,
  output logic [XLEN-1:0] rd_addr_o,
  output logic [1:0]      rd_size_o,
  input  logic            rd_vld_i,
  input  logic [XLEN-1:0] rd_data_i,
  input  logic            rd_pf_i,
  output logic            sp_we_o,
  output logic [XLEN-1:0] sp_wdata_o,
  output logic            fp_we_o,
  output logic [XLEN-1:0] fp_wdata_o,
  output logic            fault_o,
  output logic [2:0]      fault_cls_o,
  output logic            busy_o
);
  logic [1:0]      mode_q, stk_q, op_q, cpl_q;
  logic            ac_q, lock_q;
  logic [XLEN-1:0] fp_q, sp_q, lo_q, hi_q, data_q;

  logic            capture, take_data, wb;
  size_e           stk_sz, pop_sz;
  logic [XLEN-1:0] pop_addr, pop_last, sp_next, fp_next;
  fault_e          chk_cls, flt_cls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; stk_q <= '0; op_q <= '0; cpl_q <= '0;
      ac_q   <= 1'b0; lock_q <= 1'b0;
      fp_q   <= '0; sp_q <= '0; lo_q <= '0; hi_q <= '0;
    end else if (capture) begin
      mode_q <= mode_i; stk_q <= stk_size_i; op_q <= op_size_i; cpl_q <= cpl_i;
      ac_q   <= ac_en_i; lock_q <= lock_i;
      fp_q   <= fp_i; sp_q <= sp_i; lo_q <= seg_lo_i; hi_q <= seg_hi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (take_data) data_q <= rd_data_i;
  end

  frx_addr_gen #(.XLEN(XLEN)) u_addr (
    .mode_i     (mode_e'(mode_q)),
    .stk_code_i (stk_q),
    .op_code_i  (op_q),
    .fp_i       (fp_q),
    .sp_i       (sp_q),
    .stk_sz_o   (stk_sz),
    .pop_sz_o   (pop_sz),
    .pop_addr_o (pop_addr),
    .pop_last_o (pop_last),
    .sp_next_o  (sp_next)
  );

  frx_fault_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_chk (
    .mode_i     (mode_e'(mode_q)),
    .cpl_i      (cpl_q),
    .ac_en_i    (ac_q),
    .lock_i     (lock_q),
    .pop_sz_i   (pop_sz),
    .pop_addr_i (pop_addr),
    .pop_last_i (pop_last),
    .seg_lo_i   (lo_q),
    .seg_hi_i   (hi_q),
    .cls_o      (chk_cls)
  );

  frx_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .chk_cls_i   (chk_cls),
    .rd_vld_i    (rd_vld_i),
    .rd_pf_i     (rd_pf_i),
    .capture_o   (capture),
    .take_data_o (take_data),
    .busy_o      (busy_o),
    .rd_req_o    (rd_req_o),
    .wb_o        (wb),
    .fault_o     (fault_o),
    .fault_cls_o (flt_cls)
  );

  frx_merge #(.XLEN(XLEN)) u_fp_merge (
    .size_i (pop_sz),
    .old_i  (fp_q),
    .new_i  (data_q),
    .out_o  (fp_next)
  );

  logic stk_unused;
  assign stk_unused  = ^stk_sz;
  assign rd_addr_o   = pop_addr;
  assign rd_size_o   = pop_sz;
  assign sp_we_o     = wb;
  assign fp_we_o     = wb;
  assign sp_wdata_o  = sp_next;
  assign fp_wdata_o  = fp_next;
  assign fault_cls_o = flt_cls;
endmodule

// File: rtl/frx_sva.sv
module frx_sva #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            rd_req_o,
  input logic            rd_vld_i,
  input logic            rd_pf_i,
  input logic [XLEN-1:0] rd_addr_o,
  input logic            sp_we_o,
  input logic            fp_we_o,
  input logic            fault_o,
  input logic [2:0]      fault_cls_o
);
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R1
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_o || fault_o) |=> !busy_o); // R1
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_vld_i |=> rd_req_o && $stable(rd_addr_o)); // R3
  AST_WE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o == fp_we_o); // R3
  AST_DATA_TO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_vld_i && !rd_pf_i |=> sp_we_o); // R3
  AST_PF_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_vld_i && rd_pf_i |=> fault_o && fault_cls_o == 3'd5); // R10
  AST_NO_WB_ON_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !sp_we_o && !fp_we_o && fault_cls_o != 3'd0); // R11
  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o); // R11
  AST_REQ_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o && !fault_o); // R11
endmodule

bind frame_exit_seq frx_sva #(.XLEN(XLEN)) u_sva (.*);

// File: tb/tb_frame_exit_seq.sv
module tb_frame_exit_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0, stk_size_i = '0, op_size_i = '0, cpl_i = '0;
  logic        ac_en_i = 1'b0, lock_i = 1'b0;
  logic [63:0] fp_i = '0, sp_i = '0, seg_lo_i = '0, seg_hi_i = '0;
  logic        rd_req_o;
  logic [63:0] rd_addr_o;
  logic [1:0]  rd_size_o;
  logic        rd_vld_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic        rd_pf_i = 1'b0;
  logic        sp_we_o, fp_we_o, fault_o, busy_o;
  logic [63:0] sp_wdata_o, fp_wdata_o;
  logic [2:0]  fault_cls_o;

  int n_chk = 0, n_bad = 0;

  logic        seen_wb, seen_flt, late_busy;
  logic [63:0] r_addr, r_sp, r_fp;
  logic [1:0]  r_size;
  logic [2:0]  r_cls;
  int          n_req;

  always #4 clk_i = ~clk_i;

  frame_exit_seq dut (.*);

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // intr: 0 none, 1 start during read wait, 2 start in write-back cycle
  task automatic run_op(input logic [1:0] md, input logic [1:0] stk, input logic [1:0] op,
                        input logic [1:0] cpl, input logic ac, input logic lk,
                        input logic [63:0] fp, input logic [63:0] sp,
                        input logic [63:0] lo, input logic [63:0] hi,
                        input logic [63:0] data, input logic pf, input int lat, input int intr);
    logic prev_req;
    int   wait_cnt;
    logic fin;
    seen_wb = 0; seen_flt = 0; n_req = 0; late_busy = 0;
    r_addr = '0; r_sp = '0; r_fp = '0; r_size = '0; r_cls = '0;
    prev_req = 0; wait_cnt = 0; fin = 0;
    @(negedge clk_i);
    mode_i = md; stk_size_i = stk; op_size_i = op; cpl_i = cpl;
    ac_en_i = ac; lock_i = lk; fp_i = fp; sp_i = sp; seg_lo_i = lo; seg_hi_i = hi;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int c = 0; c < 60 && !fin; c++) begin
      rd_vld_i = 1'b0; rd_pf_i = 1'b0; start_i = 1'b0;
      if (fault_o) begin seen_flt = 1; r_cls = fault_cls_o; end
      if (sp_we_o) begin
        seen_wb = 1; r_sp = sp_wdata_o; r_fp = fp_wdata_o;
        if (intr == 2) begin start_i = 1'b1; fp_i = 64'h0000_0000_0000_4444; end
      end
      if (rd_req_o) begin
        if (!prev_req) begin n_req++; r_addr = rd_addr_o; r_size = rd_size_o; end
        if (wait_cnt == lat) begin
          rd_vld_i = 1'b1; rd_data_i = data; rd_pf_i = pf;
        end else begin
          wait_cnt++;
          if (intr == 1 && wait_cnt == 1) begin
            start_i = 1'b1; fp_i = 64'h0000_0000_0000_0888; sp_i = '0; lock_i = 1'b1;
          end
        end
      end
      prev_req = rd_req_o;
      if ((seen_wb || seen_flt) && !busy_o) fin = 1;
      else @(negedge clk_i);
    end
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL R1 operation did not finish: actual busy expected idle");
    end
    start_i = 1'b0;
    @(negedge clk_i);
    late_busy = busy_o | rd_req_o;
  endtask

  task automatic exp_wb(string tag, logic [63:0] addr, logic [1:0] size,
                        logic [63:0] sp, logic [63:0] fp);
    chk(tag, "write-back seen", 64'(seen_wb), 64'd1);
    chk(tag, "no fault", 64'(seen_flt), 64'd0);
    chk(tag, "one read", 64'(n_req), 64'd1);
    chk(tag, "read address", r_addr, addr);
    chk(tag, "read size", 64'(r_size), 64'(size));
    chk(tag, "stack pointer", r_sp, sp);
    chk(tag, "frame pointer", r_fp, fp);
  endtask

  task automatic exp_flt(string tag, logic [2:0] cls, int reqs);
    chk(tag, "fault seen", 64'(seen_flt), 64'd1);
    chk(tag, "fault class", 64'(r_cls), 64'(cls));
    chk(tag, "no write-back", 64'(seen_wb), 64'd0);
    chk(tag, "read count", 64'(n_req), 64'(reqs));
  endtask

  localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

  task automatic t_reset();
    chk("R1", "reset busy", 64'(busy_o), 64'd0);
    chk("R1", "reset req", 64'(rd_req_o), 64'd0);
    chk("R11", "reset strobes", 64'({sp_we_o, fp_we_o, fault_o}), 64'd0);
  endtask

  task automatic t_widths();
    run_op(2, 1, 1, 0, 0, 0, 64'h5555_6666_0000_1000, 64'h1111_2222_3333_4444,
           0, ALL, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0);
    exp_wb("R2_prot32", 64'h1000, 1, 64'h1111_2222_0000_1004, 64'h5555_6666_CAFE_F00D);
    run_op(0, 0, 0, 0, 0, 0, 64'h0000_0000_0003_2000, 64'h1234_5678_9ABC_0010,
           0, 0, 64'h1111_2222_3333_BEEF, 0, 3, 0);
    exp_wb("R2_real16", 64'h2000, 0, 64'h1234_5678_9ABC_2002, 64'h0000_0000_0003_BEEF);
    run_op(3, 0, 1, 0, 0, 0, 64'h0000_7FFF_FFFF_F000, 64'h9999_9999_9999_9999,
           0, 0, 64'h0123_4567_89AB_CDEF, 0, 1, 0);
    exp_wb("R4_long64", 64'h0000_7FFF_FFFF_F000, 2, 64'h0000_7FFF_FFFF_F008, 64'h0123_4567_89AB_CDEF);
    run_op(3, 1, 0, 3, 0, 0, 64'hFFFF_8000_0000_0100, 64'h0,
           0, 0, 64'hAAAA_BBBB_CCCC_1234, 0, 0, 0);
    exp_wb("R4_long16", 64'hFFFF_8000_0000_0100, 0, 64'hFFFF_8000_0000_0102, 64'hFFFF_8000_0000_1234);
    run_op(0, 0, 0, 0, 0, 0, 64'h0000_0000_0000_FFFE, 64'hAAAA_AAAA_AAAA_5555,
           0, 0, 64'h0000_0000_0000_7777, 0, 0, 0);
    exp_wb("R3_wrap16", 64'hFFFE, 0, 64'hAAAA_AAAA_AAAA_0000, 64'h0000_0000_0000_7777);
  endtask

  task automatic t_limits();
    run_op(0, 0, 0, 0, 0, 0, 64'hFFFF, 0, 0, 0, 0, 0, 0, 0);
    exp_flt("R6_edge", 3'd2, 0);
    run_op(1, 1, 1, 0, 0, 0, 64'h0001_0000, 0, 0, 0, 0, 0, 0, 0);
    exp_flt("R6_v86", 3'd2, 0);
    run_op(2, 1, 1, 0, 0, 0, 64'h1FFE, 0, 64'h1000, 64'h1FFF, 0, 0, 0, 0);
    exp_flt("R7_high", 3'd3, 0);
    run_op(2, 1, 1, 0, 0, 0, 64'h0FFC, 0, 64'h1000, 64'h1FFF, 0, 0, 0, 0);
    exp_flt("R7_low", 3'd3, 0);
    run_op(2, 1, 1, 0, 0, 0, 64'h1FFC, 0, 64'h1000, 64'h1FFF, 64'h55, 0, 0, 0);
    exp_wb("R7_inside", 64'h1FFC, 1, 64'h2000, 64'h55);
    run_op(3, 0, 1, 0, 0, 0, 64'h0000_8000_0000_0000, 0, 0, 0, 0, 0, 0, 0);
    exp_flt("R8_noncanon", 3'd3, 0);
  endtask

  task automatic t_align();
    run_op(2, 1, 1, 3, 1, 0, 64'h1002, 0, 0, ALL, 0, 0, 0, 0);
    exp_flt("R9_prot_cpl3", 3'd4, 0);
    run_op(2, 1, 1, 0, 1, 0, 64'h1002, 0, 0, ALL, 64'h66, 0, 0, 0);
    exp_wb("R9_prot_cpl0", 64'h1002, 1, 64'h1006, 64'h66);
    run_op(1, 0, 0, 0, 1, 0, 64'h0101, 0, 0, 0, 0, 0, 0, 0);
    exp_flt("R9_v86", 3'd4, 0);
    run_op(0, 0, 0, 3, 1, 0, 64'h0101, 0, 0, 0, 64'h77, 0, 0, 0);
    exp_wb("R9_real", 64'h0101, 0, 64'h0103, 64'h77);
    run_op(3, 0, 1, 3, 1, 0, 64'h0000_0000_0000_1004, 0, 0, 0, 0, 0, 0, 0);
    exp_flt("R9_long", 3'd4, 0);
  endtask

  task automatic t_prio();
    run_op(2, 1, 1, 0, 0, 1, 64'h1000, 0, 0, ALL, 0, 0, 0, 0);
    exp_flt("R5_lock", 3'd1, 0);
    run_op(0, 0, 0, 0, 0, 1, 64'hFFFF, 0, 0, 0, 0, 0, 0, 0);
    exp_flt("R12_lock_over_gp", 3'd1, 0);
    run_op(2, 1, 1, 3, 1, 0, 64'h1FFE, 0, 64'h1000, 64'h1FFF, 0, 0, 0, 0);
    exp_flt("R12_ss_over_ac", 3'd3, 0);
  endtask

  task automatic t_pf();
    run_op(2, 1, 1, 0, 0, 0, 64'h2000, 64'h1234, 0, ALL, 64'h99, 1, 2, 0);
    exp_flt("R10_pf", 3'd5, 1);
  endtask

  task automatic t_overlap();
    run_op(2, 1, 1, 0, 0, 0, 64'h3000, 64'h0, 0, ALL, 64'hABCD_0123, 0, 3, 1);
    exp_wb("R1_start_in_read", 64'h3000, 1, 64'h3004, 64'hABCD_0123);
    chk("R1_start_in_read", "idle after", 64'(late_busy), 64'd0);
    run_op(0, 0, 0, 0, 0, 0, 64'h0200, 64'h0, 0, 0, 64'h1357, 0, 0, 2);
    exp_wb("R1_start_in_wb", 64'h0200, 0, 64'h0202, 64'h1357);
    chk("R1_start_in_wb", "idle after", 64'(late_busy), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_widths();
    t_limits();
    t_align();
    t_prio();
    t_pf();
    t_overlap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule